// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block decides where a 32-bit fixed-length instruction stream goes next. Given the current program counter, the instruction word and the two source register values that the register file returns for the instruction's register fields, it produces the address of the following instruction. It also produces the write that the link variants make to the link register. Conditional branches compare the two register values under one of ten conditions, signed or unsigned. Direct jumps take a 26-bit relative offset. Register jumps take their target from the first source register. A return-from-exception opcode takes its target from a dedicated input.

The unit is purely combinational. The program counter register, instruction fetch, the register file and exception entry all sit outside it. The unit exposes the two decoded register indices so that the register file can be read in the same cycle. It ignores the data for an index of zero and treats that operand as zero.

Top module: `npc_unit`

## Requirements
- R1: The opcode is instruction bits 31..26. Source index A (`src_a_idx_o`) is bits 25..21 and source index B (`src_b_idx_o`) is bits 20..16. Control opcodes are: 0x20 beq, 0x21 bne, 0x22 ble, 0x23 bleu, 0x24 blt, 0x25 bltu, 0x26 bge, 0x27 bgeu, 0x28 bgt, 0x29 bgtu, 0x2A jump, 0x2B jump-register, 0x2C jump-and-link, 0x2D jump-and-link-register, 0x2F return-from-exception.
- R2: Any opcode not listed in R1 gives `next_pc_o` = PC+4 (modulo 2^32) and `link_we_o` = 0.
- R3: A taken conditional branch gives PC+4 plus the sign-extended bits 15..0 shifted left by 2. A branch that is not taken gives PC+4. No branch writes the link register.
- R4: beq is taken when A equals B, and bne is taken when they differ.
- R5: ble, blt, bge and bgt compare A and B as two's-complement signed values, for example 0x7FFFFFFF > 0x80000000.
- R6: bleu, bltu, bgeu and bgtu compare A and B as unsigned values, for example 0x80000000 > 0x7FFFFFFF.
- R7: jump and jump-and-link give PC+4 plus the sign-extended bits 25..0 shifted left by 2.
- R8: jump-and-link and jump-and-link-register assert `link_we_o`, with `link_idx_o` = 31 and `link_data_o` = PC+4. No other opcode asserts `link_we_o`.
- R9: jump-register and jump-and-link-register give operand A as the next PC. For jump-and-link-register the target is the operand value presented, even when index A is 31.
- R10: When a source index is 0, its operand is treated as zero whatever the data input carries.
- R11: return-from-exception gives `eret_target_i` as the next PC, with `link_we_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| insn_i | input | 32 | Current instruction word |
| src_a_idx_o | output | 5 | Register index A, bits 25..21 |
| src_b_idx_o | output | 5 | Register index B, bits 20..16 |
| src_a_data_i | input | 32 | Register file value for index A |
| src_b_data_i | input | 32 | Register file value for index B |
| eret_target_i | input | 32 | Saved return address for return-from-exception |
| next_pc_o | output | 32 | Address of the following instruction |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index |
| link_data_o | output | 32 | Value written to the link register |

## Verification
The unit holds no state, so a wrong internal value appears on `next_pc_o` or the link outputs in the same evaluation that applies the instruction. A wrong condition code, or a wrong sign or width choice in the comparator, shows only on operand pairs that straddle the sign boundary. For that reason the directed cases drive 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and zero against each other under all ten conditions. A wrong sign extension of an offset shows only with negative offsets, so both directions are driven for branches and for jumps.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned RIDX_W = 5;

  // Branch conditions: low opcode nibble selects the condition, order matters.
  typedef enum logic [3:0] {
    CND_EQ  = 4'd0,
    CND_NE  = 4'd1,
    CND_LE  = 4'd2,
    CND_LEU = 4'd3,
    CND_LT  = 4'd4,
    CND_LTU = 4'd5,
    CND_GE  = 4'd6,
    CND_GEU = 4'd7,
    CND_GT  = 4'd8,
    CND_GTU = 4'd9
  } cond_e;

  typedef enum logic [2:0] {
    FLOW_SEQ    = 3'd0,
    FLOW_BRANCH = 3'd1,
    FLOW_JUMP   = 3'd2,
    FLOW_JREG   = 3'd3,
    FLOW_ERET   = 3'd4
  } flow_e;

  typedef struct packed {
    flow_e flow;
    cond_e cond;
    logic  link;
  } ctl_t;

  localparam logic [OPC_W-1:0] OPC_BR_FIRST = 6'h20;
  localparam logic [OPC_W-1:0] OPC_BR_LAST  = 6'h29;
  localparam logic [OPC_W-1:0] OPC_JMP      = 6'h2A;
  localparam logic [OPC_W-1:0] OPC_JMPR     = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_JAL      = 6'h2C;
  localparam logic [OPC_W-1:0] OPC_JALR     = 6'h2D;
  localparam logic [OPC_W-1:0] OPC_ERET     = 6'h2F;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int unsigned IW = INSN_W,
  parameter int unsigned OW = OPC_W,
  parameter int unsigned RW = RIDX_W
) (
  input  logic [IW-1:0] insn_i,
  output ctl_t          ctl_o,
  output logic [RW-1:0] idx_a_o,
  output logic [RW-1:0] idx_b_o,
  output logic [15:0]   imm16_o,
  output logic [25:0]   off26_o
);

  localparam int unsigned OPC_LSB = IW - OW;
  localparam int unsigned A_LSB   = OPC_LSB - RW;
  localparam int unsigned B_LSB   = A_LSB - RW;

  logic [OW-1:0] opc;

  assign opc     = insn_i[IW-1:OPC_LSB];
  assign idx_a_o = insn_i[OPC_LSB-1:A_LSB];
  assign idx_b_o = insn_i[A_LSB-1:B_LSB];
  assign imm16_o = insn_i[15:0];
  assign off26_o = insn_i[25:0];

  always_comb begin
    ctl_o.flow = FLOW_SEQ;
    ctl_o.cond = CND_EQ;
    ctl_o.link = 1'b0;
    if (opc >= OPC_BR_FIRST && opc <= OPC_BR_LAST) begin
      ctl_o.flow = FLOW_BRANCH;
      ctl_o.cond = cond_e'(opc[3:0]);
    end else begin
      unique case (opc)
        OPC_JMP:  ctl_o.flow = FLOW_JUMP;
        OPC_JAL:  begin ctl_o.flow = FLOW_JUMP; ctl_o.link = 1'b1; end
        OPC_JMPR: ctl_o.flow = FLOW_JREG;
        OPC_JALR: begin ctl_o.flow = FLOW_JREG; ctl_o.link = 1'b1; end
        OPC_ERET: ctl_o.flow = FLOW_ERET;
        default:  ctl_o.flow = FLOW_SEQ;
      endcase
    end
  end

  // R8
  always_comb begin
    link_only_jump_chk: assert (!ctl_o.link || ctl_o.flow == FLOW_JUMP || ctl_o.flow == FLOW_JREG)
      else $error("link flagged on non-jump flow");
  end

endmodule

// File: rtl/npc_compare.sv
module npc_compare
  import npc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  cond_e        cond_i,
  output logic         taken_o
);

  logic eq, lt_u, lt_s;

  assign eq   = (a_i == b_i);
  assign lt_u = (a_i < b_i);
  // Signed order: flip the sign bits and reuse an unsigned compare.
  assign lt_s = ({~a_i[W-1], a_i[W-2:0]} < {~b_i[W-1], b_i[W-2:0]});

  always_comb begin
    unique case (cond_i)
      CND_EQ:  taken_o = eq;
      CND_NE:  taken_o = !eq;
      CND_LE:  taken_o = lt_s | eq;
      CND_LEU: taken_o = lt_u | eq;
      CND_LT:  taken_o = lt_s;
      CND_LTU: taken_o = lt_u;
      CND_GE:  taken_o = !lt_s;
      CND_GEU: taken_o = !lt_u;
      CND_GT:  taken_o = !(lt_s | eq);
      CND_GTU: taken_o = !(lt_u | eq);
      default: taken_o = 1'b0;
    endcase
  end

  // R4
  always_comb begin
    eq_taken_chk: assert (!(cond_i == CND_EQ && taken_o) || (a_i == b_i))
      else $error("equal branch taken on different operands");
  end

  // R5
  always_comb begin
    signed_sign_chk: assert (!(cond_i == CND_LT && a_i[W-1] != b_i[W-1]) || (taken_o == a_i[W-1]))
      else $error("signed less-than wrong across sign boundary");
  end

  // R6
  always_comb begin
    unsigned_sign_chk: assert (!(cond_i == CND_LTU && a_i[W-1] != b_i[W-1]) || (taken_o == b_i[W-1]))
      else $error("unsigned less-than wrong across sign boundary");
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] pc_i,
  input  logic [15:0]  imm16_i,
  input  logic [25:0]  off26_i,
  input  logic [W-1:0] reg_a_i,
  input  logic [W-1:0] eret_i,
  input  flow_e        flow_i,
  input  logic         taken_i,
  output logic [W-1:0] seq_o,
  output logic [W-1:0] next_o
);

  localparam int unsigned BR_EXT = W - 18;
  localparam int unsigned JP_EXT = W - 28;
  localparam logic [W-1:0] STEP  = W'(4);

  logic [W-1:0] br_disp, jp_disp;

  assign seq_o   = pc_i + STEP;
  assign br_disp = {{BR_EXT{imm16_i[15]}}, imm16_i, 2'b00};
  assign jp_disp = {{JP_EXT{off26_i[25]}}, off26_i, 2'b00};

  always_comb begin
    unique case (flow_i)
      FLOW_BRANCH: next_o = taken_i ? (seq_o + br_disp) : seq_o;
      FLOW_JUMP:   next_o = seq_o + jp_disp;
      FLOW_JREG:   next_o = reg_a_i;
      FLOW_ERET:   next_o = eret_i;
      default:     next_o = seq_o;
    endcase
  end

  // R3
  always_comb begin
    untaken_seq_chk: assert (!(flow_i == FLOW_BRANCH && !taken_i) || next_o == pc_i + STEP)
      else $error("untaken branch left sequential path");
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned IDX_W    = RIDX_W,
  parameter int unsigned LINK_REG = 31
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  insn_i,
  output logic [IDX_W-1:0] src_a_idx_o,
  output logic [IDX_W-1:0] src_b_idx_o,
  input  logic [XLEN-1:0]  src_a_data_i,
  input  logic [XLEN-1:0]  src_b_data_i,
  input  logic [XLEN-1:0]  eret_target_i,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             link_we_o,
  output logic [IDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]  link_data_o
);

  localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(LINK_REG);
  localparam bit LINK_LIVE = (LINK_REG != 0);

  ctl_t             ctl;
  logic [15:0]      imm16;
  logic [25:0]      off26;
  logic [XLEN-1:0]  opnd_a, opnd_b, seq_pc;
  logic             taken;

  npc_decode #(.IW(XLEN), .OW(OPC_W), .RW(IDX_W)) u_decode (
    .insn_i  (insn_i),
    .ctl_o   (ctl),
    .idx_a_o (src_a_idx_o),
    .idx_b_o (src_b_idx_o),
    .imm16_o (imm16),
    .off26_o (off26)
  );

  // Index zero is hardwired to zero regardless of the returned data.
  assign opnd_a = (src_a_idx_o == '0) ? '0 : src_a_data_i;
  assign opnd_b = (src_b_idx_o == '0) ? '0 : src_b_data_i;

  npc_compare #(.W(XLEN)) u_compare (
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .cond_i  (ctl.cond),
    .taken_o (taken)
  );

  npc_target #(.W(XLEN)) u_target (
    .pc_i    (pc_i),
    .imm16_i (imm16),
    .off26_i (off26),
    .reg_a_i (opnd_a),
    .eret_i  (eret_target_i),
    .flow_i  (ctl.flow),
    .taken_i (taken),
    .seq_o   (seq_pc),
    .next_o  (next_pc_o)
  );

  generate
    if (LINK_LIVE) begin : g_link
      assign link_we_o = ctl.link;
    end else begin : g_link_dropped
      assign link_we_o = 1'b0;
    end
  endgenerate

  assign link_idx_o  = LINK_IDX;
  assign link_data_o = seq_pc;

  // R8
  always_comb begin
    link_value_chk: assert (!link_we_o || link_data_o == pc_i + XLEN'(4))
      else $error("link value is not the sequential address");
  end

  // R10
  always_comb begin
    zero_reg_jump_chk: assert (!(ctl.flow == FLOW_JREG && src_a_idx_o == '0) || next_pc_o == '0)
      else $error("register jump through index zero not zero");
  end

  // R2
  always_comb begin
    seq_flow_chk: assert (!(ctl.flow == FLOW_SEQ) || (next_pc_o == pc_i + XLEN'(4) && !link_we_o))
      else $error("non-control opcode changed flow");
  end

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

  logic        clk;
  logic [31:0] pc, insn, da, db, eret;
  logic [4:0]  ia, ib, lidx;
  logic [31:0] npc, ldata;
  logic        lwe;
  int          n_chk, n_bad;
  bit          done;

  npc_unit u_dut (
    .pc_i          (pc),
    .insn_i        (insn),
    .src_a_idx_o   (ia),
    .src_b_idx_o   (ib),
    .src_a_data_i  (da),
    .src_b_data_i  (db),
    .eret_target_i (eret),
    .next_pc_o     (npc),
    .link_we_o     (lwe),
    .link_idx_o    (lidx),
    .link_data_o   (ldata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
                                     input logic [4:0] b, input logic [15:0] imm);
    return {op, a, b, imm};
  endfunction

  function automatic bit exp_take(input int c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) <= $signed(b);
      3: return a <= b;
      4: return $signed(a) <  $signed(b);
      5: return a <  b;
      6: return $signed(a) >= $signed(b);
      7: return a >= b;
      8: return $signed(a) >  $signed(b);
      default: return a > b;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [31:0] i,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] e);
    @(negedge clk);
    pc = p; insn = i; da = a; db = b; eret = e;
    #1;
  endtask

  task automatic t_idle;
    apply(32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
    check("R2 idle next", npc, 32'h4);
    check("R8 idle link_we", {31'h0, lwe}, 32'h0);
  endtask

  task automatic t_fields;
    apply(32'h100, {6'h2A, 5'd19, 5'd6, 5'd27, 11'h0}, 32'h0, 32'h0, 32'h0);
    check("R1 index A", {27'h0, ia}, 32'd19);
    check("R1 index B", {27'h0, ib}, 32'd6);
  endtask

  task automatic t_seq;
    apply(32'h0000_2000, mk(6'h05, 5'd3, 5'd4, 16'h1234), 32'h1, 32'h1, 32'hDEAD_0000);
    check("R2 other opcode", npc, 32'h0000_2004);
    check("R2 other link_we", {31'h0, lwe}, 32'h0);
    apply(32'h0000_3000, mk(6'h2E, 5'd3, 5'd4, 16'h0040), 32'h1, 32'h1, 32'h0);
    check("R2 unused 0x2E", npc, 32'h0000_3004);
    apply(32'hFFFF_FFFC, mk(6'h3F, 5'd0, 5'd0, 16'h0), 32'h0, 32'h0, 32'h0);
    check("R2 wrap", npc, 32'h0);
  endtask

  task automatic t_conditions;
    logic [31:0] va [8] = '{32'h0, 32'h1, 32'h0, 32'h7FFF_FFFF, 32'h8000_0000,
                             32'hFFFF_FFFF, 32'h0, 32'h8000_0000};
    logic [31:0] vb [8] = '{32'h0, 32'h0, 32'h1, 32'h8000_0000, 32'h7FFF_FFFF,
                             32'h0, 32'hFFFF_FFFF, 32'h8000_0000};
    for (int c = 0; c < 10; c++) begin
      for (int k = 0; k < 8; k++) begin
        logic [15:0] imm;
        logic [31:0] exp;
        string tag;
        imm = (k % 2 == 0) ? 16'h0010 : 16'hFFFE;
        exp = 32'h0000_1004;
        if (exp_take(c, va[k], vb[k])) exp = exp + {{14{imm[15]}}, imm, 2'b00};
        tag = (c < 2) ? "R4" : ((c % 2 == 0) ? "R5" : "R6");
        apply(32'h0000_1000, mk(6'h20 + 6'(c), 5'd7, 5'd9, imm), va[k], vb[k], 32'h0);
        check($sformatf("%s R3 cond %0d pair %0d", tag, c, k), npc, exp);
        check($sformatf("R3 cond %0d no link", c), {31'h0, lwe}, 32'h0);
      end
    end
  endtask

  task automatic t_jumps;
    apply(32'h0001_0000, {6'h2A, 26'h000_0100}, 32'h0, 32'h0, 32'h0);
    check("R7 jump forward", npc, 32'h0001_0404);
    apply(32'h0001_0000, {6'h2A, 26'h3FF_FFFF}, 32'h0, 32'h0, 32'h0);
    check("R7 jump back", npc, 32'h0001_0000);
    apply(32'h0000_0040, {6'h2C, 26'h3FF_FFF0}, 32'h0, 32'h0, 32'h0);
    check("R7 jal target", npc, 32'h0000_0004);
    check("R8 jal we", {31'h0, lwe}, 32'h1);
    check("R8 jal idx", {27'h0, lidx}, 32'd31);
    check("R8 jal data", ldata, 32'h0000_0044);
  endtask

  task automatic t_regjumps;
    apply(32'h0000_5000, mk(6'h2B, 5'd12, 5'd0, 16'h0), 32'hCAFE_0010, 32'h0, 32'h0);
    check("R9 jr target", npc, 32'hCAFE_0010);
    check("R9 jr no link", {31'h0, lwe}, 32'h0);
    apply(32'h0000_6000, mk(6'h2D, 5'd31, 5'd0, 16'h0), 32'h0000_0800, 32'h0, 32'h0);
    check("R9 jalr via r31 target", npc, 32'h0000_0800);
    check("R8 jalr data", ldata, 32'h0000_6004);
    check("R8 jalr we", {31'h0, lwe}, 32'h1);
  endtask

  task automatic t_zero;
    apply(32'h0000_7000, mk(6'h2B, 5'd0, 5'd0, 16'h0), 32'h1234_5678, 32'h0, 32'h0);
    check("R10 jr index zero", npc, 32'h0);
    apply(32'h0000_7000, mk(6'h20, 5'd0, 5'd0, 16'h0008), 32'h5, 32'h9, 32'h0);
    check("R10 beq both zero idx", npc, 32'h0000_7024);
    apply(32'h0000_7000, mk(6'h21, 5'd0, 5'd4, 16'h0008), 32'h5, 32'h0, 32'h0);
    check("R10 bne zero vs zero", npc, 32'h0000_7004);
  endtask

  task automatic t_eret;
    apply(32'h0000_8000, mk(6'h2F, 5'd3, 5'd4, 16'h0010), 32'h1, 32'h2, 32'h0000_ABC0);
    check("R11 eret target", npc, 32'h0000_ABC0);
    check("R11 eret no link", {31'h0, lwe}, 32'h0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    pc = '0; insn = '0; da = '0; db = '0; eret = '0;
    t_idle();
    t_fields();
    t_seq();
    t_conditions();
    t_jumps();
    t_regjumps();
    t_zero();
    t_eret();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule